// File: doc/BRIEF.md
# Bidirectional Registered Transceiver with Byte Parity

This block moves a 16-bit word, split into two bytes that each carry one parity bit, between an A side and a B side. Each direction has its own storage stage. The stage is a level-sensitive holding element followed by an edge-captured element, all built in the system clock domain. Each direction has three controls:

- a pass-through enable, which makes the stage transparent;
- a capture strobe, whose rising edge loads the stage;
- an active-low output enable, which drives that direction's output pads.

The A-to-B direction can build fresh parity from the A-side data, or carry the parity it receives and check it. The B-to-A direction only checks. One parity-sense input is shared by both directions. Each direction reports errors on one active-low flag, modelled as an open-drain pad. Each three-state pad group is modelled as a value output plus an enable output. Pad electrical behaviour is not modelled.

A typical use is a bridge between two byte-parity buses. One direction regenerates parity for a data source that has none. The other direction checks what returns.

Top module: `parity_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both storage stages and both strobe edge detectors to zero. After reset, with the pass-through enables low, every data and parity output reads 0.
- R2: While a direction's pass-through enable is 1, its data outputs equal its data inputs in the same cycle.
- R3: While the pass-through enable is 0, a strobe that is 1 in a cycle where it was 0 in the previous cycle makes the stage load its input at the next clock edge. The loaded value appears on the outputs from the following cycle.
- R4: While the pass-through enable is 0 and no strobe rising edge occurs, the stage outputs keep their value.
- R5: Bits 7:0 pair with parity bit 0 and bits 15:8 pair with parity bit 1, on both sides. With `ab_gen`=1, the A-to-B parity is built from the A-side data before the stage: parity bit k is the XOR of byte k, inverted when `odd_sel`=1. The A-side parity inputs then have no effect on any output.
- R6: With `ab_gen`=0, the received A-side parity passes through the stage unchanged. B-to-A parity always passes through unchanged.
- R7: With `ab_gen`=0 and `ab_oe_n`=0, `err_b_n` is 0 and `err_b_oe` is 1 exactly when either byte at the stage output fails the check. Under `odd_sel`=1 a byte fails when its 8 bits plus its parity bit hold an even number of ones; under `odd_sel`=0 it fails when they hold an odd number.
- R8: The B-to-A direction checks its stage output under the same rule whatever `ab_gen` is, and reports on `err_a_n`/`err_a_oe` while `ba_oe_n`=0.
- R9: While a direction's output enable is 1 (inactive), its error flag reads `err_*_n`=1 with `err_*_oe`=0, and its pad enable output is 0. While the output enable is 0, the pad enable output is 1.
- R10: With `ab_gen`=1 the A-to-B error flag never asserts.
- R11: The two directions share only `odd_sel`. The controls and data of one direction do not change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_data_i | input | 16 | A-side data in (A-to-B source) |
| a_par_i | input | 2 | A-side parity in, one bit per byte |
| a_data_o | output | 16 | A-side data out (B-to-A result) |
| a_par_o | output | 2 | A-side parity out |
| a_oe_o | output | 1 | A-side pad drive enable |
| b_data_i | input | 16 | B-side data in (B-to-A source) |
| b_par_i | input | 2 | B-side parity in |
| b_data_o | output | 16 | B-side data out (A-to-B result) |
| b_par_o | output | 2 | B-side parity out |
| b_oe_o | output | 1 | B-side pad drive enable |
| ab_pass | input | 1 | A-to-B pass-through enable |
| ab_strb | input | 1 | A-to-B capture strobe |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_pass | input | 1 | B-to-A pass-through enable |
| ba_strb | input | 1 | B-to-A capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ab_gen | input | 1 | 1: A-to-B generates parity; 0: checks it |
| odd_sel | input | 1 | 1: odd parity; 0: even parity (both directions) |
| err_b_n | output | 1 | A-to-B error flag, active low |
| err_b_oe | output | 1 | Drive enable of the A-to-B error flag |
| err_a_n | output | 1 | B-to-A error flag, active low |
| err_a_oe | output | 1 | Drive enable of the B-to-A error flag |

## Verification
The hold property assumes that a strobe low in the previous cycle rules out a capture. It also assumes that reset held in the previous cycle rules out any comparison across the reset boundary. The pass-through properties assume that inputs change only once per system clock. The bench keeps to these assumptions by changing every input at the falling clock edge and holding it until the next one. The strobe is random, so captures, holds and long strobe-high runs all occur.

// File: rtl/pxcvr_pkg.sv
// Package: shared sizes and encodings for the byte-parity transceiver.
// Assumes the word is a whole number of bytes, each with one parity bit.
package pxcvr_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned N_BYTES = 2;
    localparam int unsigned DATA_W  = BYTE_W * N_BYTES;
    localparam int unsigned LANE_W  = DATA_W + N_BYTES;

    // Parity sense carried by the shared select input
    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_e;

    // Operating mode of the A-to-B parity path
    typedef enum logic {
        AB_CHECK = 1'b0,
        AB_GEN   = 1'b1
    } ab_mode_e;

endpackage

// File: rtl/pxcvr_stage.sv
// Module: one direction's storage stage.
// Behaviour: pass=1 makes the stage transparent (q follows d in the same
// cycle) and keeps the holding register loaded so that it keeps the last
// value when pass falls. With pass=0, a rising edge on strb, found by
// comparing with the previous cycle's strb, loads d at the clock edge.
// Otherwise the register holds. Assumes strb is synchronous to clk.
module pxcvr_stage #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass,
    input  logic         strb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic         strb_q;
    logic         strb_rise;
    logic [W-1:0] hold_q;

    // Rising edge of the capture strobe in this cycle
    assign strb_rise = strb & ~strb_q;

    // Strobe history register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
        end else begin
            strb_q <= strb;
        end
    end

    // Holding register: load while transparent or on a strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (pass || strb_rise) begin
            hold_q <= d;
        end
    end

    // Output select: live input when transparent, stored value otherwise
    always_comb begin
        q = pass ? d : hold_q;
    end

endmodule

// File: rtl/pxcvr_pargen.sv
// Module: per-byte parity builder.
// Byte k is bits [k*BYTE_W +: BYTE_W] and its parity goes to par[k]. The
// parity bit makes the byte plus parity hold an even number of ones for
// SENSE_EVEN and an odd number for SENSE_ODD. Purely combinational.
module pxcvr_pargen
    import pxcvr_pkg::*;
#(
    parameter int unsigned BW = 8,
    parameter int unsigned NB = 2
) (
    input  logic [BW*NB-1:0] data,
    input  par_sense_e       sense,
    output logic [NB-1:0]    par
);

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic ones_odd;
        // Reduction over one byte
        assign ones_odd = ^data[k*BW +: BW];
        // Flip the bit when odd sense is selected
        assign par[k]   = ones_odd ^ (sense == SENSE_ODD);
    end

endmodule

// File: rtl/pxcvr_parchk.sv
// Module: per-byte parity checker.
// Flags each byte whose data plus parity bit breaks the selected sense and
// ORs the flags into one error bit. Purely combinational; uses the same
// byte layout as pxcvr_pargen.
module pxcvr_parchk
    import pxcvr_pkg::*;
#(
    parameter int unsigned BW = 8,
    parameter int unsigned NB = 2
) (
    input  logic [BW*NB-1:0] data,
    input  logic [NB-1:0]    par,
    input  par_sense_e       sense,
    output logic [NB-1:0]    byte_bad,
    output logic             any_bad
);

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic group_odd;
        // Ones count of byte plus its parity bit, reduced to one bit
        assign group_odd   = (^data[k*BW +: BW]) ^ par[k];
        // Bad when the count does not match the selected sense
        assign byte_bad[k] = group_odd ^ (sense == SENSE_ODD);
    end

    // Any byte failing makes the direction fail
    assign any_bad = |byte_bad;

endmodule

// File: rtl/parity_xcvr.sv
// Module: top of the bidirectional transceiver with byte parity.
// A-to-B: optional parity build before the stage, check after the stage in
// check mode only. B-to-A: received parity always stored and checked after
// the stage. Error flags are active low and model an open-drain pad: the
// drive enable is high only while an error is reported, and never while the
// direction's output enable is inactive. Assumes all inputs are synchronous
// to clk.
module parity_xcvr
    import pxcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic [N_BYTES-1:0] a_par_i,
    output logic [DATA_W-1:0] a_data_o,
    output logic [N_BYTES-1:0] a_par_o,
    output logic              a_oe_o,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic [N_BYTES-1:0] b_par_i,
    output logic [DATA_W-1:0] b_data_o,
    output logic [N_BYTES-1:0] b_par_o,
    output logic              b_oe_o,
    input  logic              ab_pass,
    input  logic              ab_strb,
    input  logic              ab_oe_n,
    input  logic              ba_pass,
    input  logic              ba_strb,
    input  logic              ba_oe_n,
    input  logic              ab_gen,
    input  logic              odd_sel,
    output logic              err_b_n,
    output logic              err_b_oe,
    output logic              err_a_n,
    output logic              err_a_oe
);

    par_sense_e            sense;
    ab_mode_e              ab_mode;
    logic [N_BYTES-1:0]    ab_built_par;
    logic [N_BYTES-1:0]    ab_in_par;
    logic [LANE_W-1:0]     ab_lane_q;
    logic [LANE_W-1:0]     ba_lane_q;
    logic [N_BYTES-1:0]    ab_byte_bad;
    logic [N_BYTES-1:0]    ba_byte_bad;
    logic                  ab_bad;
    logic                  ba_bad;
    logic                  ab_report;
    logic                  ba_report;

    // Decode the shared sense and the A-to-B mode
    assign sense   = par_sense_e'(odd_sel);
    assign ab_mode = ab_mode_e'(ab_gen);

    // A-to-B parity built from the A-side data ahead of the stage
    pxcvr_pargen #(.BW(BYTE_W), .NB(N_BYTES)) u_ab_gen (
        .data  (a_data_i),
        .sense (sense),
        .par   (ab_built_par)
    );

    // Parity entering the A-to-B stage: built bits or received bits
    always_comb begin
        ab_in_par = (ab_mode == AB_GEN) ? ab_built_par : a_par_i;
    end

    // A-to-B storage stage carrying data and parity together
    pxcvr_stage #(.W(LANE_W)) u_ab_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .pass  (ab_pass),
        .strb  (ab_strb),
        .d     ({ab_in_par, a_data_i}),
        .q     (ab_lane_q)
    );

    // B-to-A storage stage carrying data and parity together
    pxcvr_stage #(.W(LANE_W)) u_ba_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .pass  (ba_pass),
        .strb  (ba_strb),
        .d     ({b_par_i, b_data_i}),
        .q     (ba_lane_q)
    );

    // A-to-B check on the stage output
    pxcvr_parchk #(.BW(BYTE_W), .NB(N_BYTES)) u_ab_chk (
        .data     (ab_lane_q[DATA_W-1:0]),
        .par      (ab_lane_q[LANE_W-1:DATA_W]),
        .sense    (sense),
        .byte_bad (ab_byte_bad),
        .any_bad  (ab_bad)
    );

    // B-to-A check on the stage output
    pxcvr_parchk #(.BW(BYTE_W), .NB(N_BYTES)) u_ba_chk (
        .data     (ba_lane_q[DATA_W-1:0]),
        .par      (ba_lane_q[LANE_W-1:DATA_W]),
        .sense    (sense),
        .byte_bad (ba_byte_bad),
        .any_bad  (ba_bad)
    );

    // Split the stage outputs onto the pad value outputs
    assign b_data_o = ab_lane_q[DATA_W-1:0];
    assign b_par_o  = ab_lane_q[LANE_W-1:DATA_W];
    assign a_data_o = ba_lane_q[DATA_W-1:0];
    assign a_par_o  = ba_lane_q[LANE_W-1:DATA_W];

    // Pad drive enables follow the active-low output enables
    assign b_oe_o = ~ab_oe_n;
    assign a_oe_o = ~ba_oe_n;

    // Report only in check mode (A-to-B) and only while enabled
    always_comb begin
        ab_report = ab_bad & (ab_mode == AB_CHECK) & ~ab_oe_n;
        ba_report = ba_bad & ~ba_oe_n;
    end

    // Open-drain style flags: pull low and drive only while reporting
    assign err_b_n  = ~ab_report;
    assign err_b_oe = ab_report;
    assign err_a_n  = ~ba_report;
    assign err_a_oe = ba_report;

endmodule

// File: rtl/pxcvr_checker.sv
// Module: property checker for parity_xcvr, attached by bind.
// Assumes inputs change once per clock and the reset is synchronous.
module pxcvr_checker
    import pxcvr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_data_i,
    input logic [DATA_W-1:0] b_data_i,
    input logic [DATA_W-1:0] a_data_o,
    input logic [DATA_W-1:0] b_data_o,
    input logic              a_oe_o,
    input logic              b_oe_o,
    input logic              ab_pass,
    input logic              ab_strb,
    input logic              ab_oe_n,
    input logic              ba_pass,
    input logic              ba_strb,
    input logic              ba_oe_n,
    input logic              ab_gen,
    input logic              err_b_n,
    input logic              err_b_oe,
    input logic              err_a_n,
    input logic              err_a_oe
);

    AST_AB_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ab_pass |-> (b_data_o == a_data_i)); // R2

    AST_BA_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ba_pass |-> (a_data_o == b_data_i)); // R2

    AST_AB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_pass && !$past(ab_pass) && !$past(ab_strb) && $past(rst_n))
        |-> $stable(b_data_o)); // R4

    AST_BA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_pass && !$past(ba_pass) && !$past(ba_strb) && $past(rst_n))
        |-> $stable(a_data_o)); // R4

    AST_ERRB_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> (err_b_n && !err_b_oe && !b_oe_o)); // R9

    AST_ERRA_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> (err_a_n && !err_a_oe && !a_oe_o)); // R9

    AST_GEN_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        ab_gen |-> !err_b_oe); // R10

    AST_ERRB_LOW_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        err_b_oe |-> !err_b_n); // R7

    AST_ERRA_LOW_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        err_a_oe |-> !err_a_n); // R8

endmodule

bind parity_xcvr pxcvr_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_data_i (a_data_i),
    .b_data_i (b_data_i),
    .a_data_o (a_data_o),
    .b_data_o (b_data_o),
    .a_oe_o   (a_oe_o),
    .b_oe_o   (b_oe_o),
    .ab_pass  (ab_pass),
    .ab_strb  (ab_strb),
    .ab_oe_n  (ab_oe_n),
    .ba_pass  (ba_pass),
    .ba_strb  (ba_strb),
    .ba_oe_n  (ba_oe_n),
    .ab_gen   (ab_gen),
    .err_b_n  (err_b_n),
    .err_b_oe (err_b_oe),
    .err_a_n  (err_a_n),
    .err_a_oe (err_a_oe)
);

// File: tb/parity_xcvr_tb_top.sv
// Bench: directed corner cases plus seeded random traffic. Every output is
// checked against a model built from the requirements. Inputs change at the
// falling edge; outputs are sampled 2 ns later.
module parity_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] a_data_i, b_data_i, a_data_o, b_data_o;
    logic [1:0]  a_par_i, b_par_i, a_par_o, b_par_o;
    logic        a_oe_o, b_oe_o;
    logic        ab_pass, ab_strb, ab_oe_n, ba_pass, ba_strb, ba_oe_n;
    logic        ab_gen, odd_sel;
    logic        err_b_n, err_b_oe, err_a_n, err_a_oe;

    int n_chk = 0;
    int n_err = 0;

    // Model state
    logic [17:0] m_ab, m_ba;
    logic        m_ab_sq, m_ba_sq, m_ab_cap, m_ba_cap;

    always #5 clk = ~clk;

    parity_xcvr dut_i (.*);

    function automatic logic [1:0] ref_par(input logic [15:0] d, input logic odd);
        logic [1:0] p;
        for (int k = 0; k < 2; k++) begin
            int c = 0;
            for (int i = 0; i < 8; i++) c += d[k*8+i];
            p[k] = c[0] ^ odd;
        end
        return p;
    endfunction

    function automatic logic ref_bad(input logic [15:0] d, input logic [1:0] p, input logic odd);
        logic bad = 1'b0;
        for (int k = 0; k < 2; k++) begin
            int c = p[k];
            for (int i = 0; i < 8; i++) c += d[k*8+i];
            if (c[0] != odd) bad = 1'b1;
        end
        return bad;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs, then advance one clock and update the model
    task automatic step();
        logic [17:0] ab_in, ba_in, ab_o, ba_o;
        logic        eb, ea;
        #2;
        ab_in = {ab_gen ? ref_par(a_data_i, odd_sel) : a_par_i, a_data_i};
        ba_in = {b_par_i, b_data_i};
        ab_o  = ab_pass ? ab_in : m_ab;
        ba_o  = ba_pass ? ba_in : m_ba;
        eb = !ab_oe_n && !ab_gen && ref_bad(ab_o[15:0], ab_o[17:16], odd_sel);
        ea = !ba_oe_n && ref_bad(ba_o[15:0], ba_o[17:16], odd_sel);
        chk(ab_pass ? "R2 B data" : (m_ab_cap ? "R3 B data" : "R4 B data"),
            32'(b_data_o), 32'(ab_o[15:0]));
        chk(ab_gen ? "R5 B parity" : "R6 B parity", 32'(b_par_o), 32'(ab_o[17:16]));
        chk(ba_pass ? "R2 A data" : (m_ba_cap ? "R3 A data" : "R4 A data"),
            32'(a_data_o), 32'(ba_o[15:0]));
        chk("R6 A parity", 32'(a_par_o), 32'(ba_o[17:16]));
        chk(ab_oe_n ? "R9 B flag" : (ab_gen ? "R10 B flag" : "R7 B flag"),
            32'({err_b_n, err_b_oe}), 32'({~eb, eb}));
        chk(ba_oe_n ? "R9 A flag" : "R8 A flag", 32'({err_a_n, err_a_oe}), 32'({~ea, ea}));
        chk("R9 pad enables", 32'({a_oe_o, b_oe_o}), 32'({~ba_oe_n, ~ab_oe_n}));
        @(posedge clk);
        m_ab_cap = !ab_pass && ab_strb && !m_ab_sq;
        m_ba_cap = !ba_pass && ba_strb && !m_ba_sq;
        if (ab_pass || m_ab_cap) m_ab = ab_in;
        if (ba_pass || m_ba_cap) m_ba = ba_in;
        m_ab_sq = ab_strb;
        m_ba_sq = ba_strb;
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned r;
        rst_n = 1'b0;
        a_data_i = '0; b_data_i = '0; a_par_i = '0; b_par_i = '0;
        ab_pass = 0; ab_strb = 0; ab_oe_n = 0; ba_pass = 0; ba_strb = 0; ba_oe_n = 0;
        ab_gen = 0; odd_sel = 0;
        repeat (3) @(posedge clk);
        m_ab = '0; m_ba = '0; m_ab_sq = 0; m_ba_sq = 0; m_ab_cap = 0; m_ba_cap = 0;
        @(negedge clk);
        rst_n = 1'b1;
        a_data_i = 16'hFFFF; b_data_i = 16'hFFFF; a_par_i = 2'b11; b_par_i = 2'b11;
        #2;
        // R1: storage cleared, non-transparent outputs read zero
        chk("R1 reset B", 32'({b_par_o, b_data_o}), 32'h0);
        chk("R1 reset A", 32'({a_par_o, a_data_o}), 32'h0);
        #(-2 + 2);
        step();

        // R3: strobe rising edge captures on both sides
        a_data_i = 16'h12A5; b_data_i = 16'h5A0F; b_par_i = 2'b10; a_par_i = 2'b01;
        ab_strb = 1; ba_strb = 1;
        step();
        // R4: strobe held high and inputs changing, no new capture
        a_data_i = 16'hFFFF; b_data_i = 16'h0000;
        step();
        ab_strb = 0; ba_strb = 0;
        step();

        // R5: generate mode, parity pins ignored, odd and even, pass-through
        ab_gen = 1; ab_pass = 1;
        for (int s = 0; s < 2; s++) begin
            odd_sel = s[0];
            a_data_i = 16'h0301;
            a_par_i = 2'b00; step();
            a_par_i = 2'b11; step();
        end

        // R7: check mode, single-byte error in each byte, both senses
        ab_gen = 0;
        for (int s = 0; s < 2; s++) begin
            odd_sel = s[0];
            a_data_i = 16'h7F01;
            a_par_i = ref_par(a_data_i, odd_sel); step();
            a_par_i = ref_par(a_data_i, odd_sel) ^ 2'b01; step();
            a_par_i = ref_par(a_data_i, odd_sel) ^ 2'b10; step();
            // R9: same error with output disabled
            ab_oe_n = 1; step(); ab_oe_n = 0;
        end

        // R8 and R11: B-to-A checks in generate mode; A-to-B controls move
        ab_gen = 1; ba_pass = 1;
        b_data_i = 16'h8001; b_par_i = ref_par(b_data_i, odd_sel) ^ 2'b10;
        step();
        ab_pass = 0; ab_strb = 1; a_data_i = 16'h4444; step();
        ab_strb = 0; step();

        // Seeded random traffic
        r = $urandom(32'd2718);
        for (int n = 0; n < 600; n++) begin
            r = $urandom();
            a_data_i = 16'($urandom()); b_data_i = 16'($urandom());
            ab_pass = (r[1:0] == 2'd0); ba_pass = (r[3:2] == 2'd0);
            ab_strb = r[4]; ba_strb = r[5];
            ab_oe_n = (r[7:6] == 2'd0); ba_oe_n = (r[9:8] == 2'd0);
            ab_gen = r[10];
            if (r[15:11] == 5'd0) odd_sel = ~odd_sel;
            a_par_i = ref_par(a_data_i, odd_sel) ^ ((r[17:16] == 2'd0) ? 2'(r[19:18]) : 2'b00);
            b_par_i = ref_par(b_data_i, odd_sel) ^ ((r[21:20] == 2'd0) ? 2'(r[23:22]) : 2'b00);
            step();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule